// File: doc/BRIEF.md
# Down-Counting Event Timer

A single-channel timer peripheral that sits on a simple 32-bit register bus with APB-style setup and access phases and counts down once per clock. Software programs a 64-bit start value as two 32-bit words. It then sets the run bit in the control word, and the counter takes that start value in the same clock edge. The running count can be read back at any time as two words. Bus and timer share one clock, and there is no prescaler.

Two operating styles are offered. In the periodic style the counter reloads itself every time it reaches zero, so a start value of N-1 gives one event every N clocks. In the single-shot style it counts down once, reports one event and then rests at zero until it is stopped and started again. Each event sets a sticky pending flag, which software clears by writing a one to it. The interrupt line is that flag gated by a separate interrupt-enable bit. A build parameter places the control word at byte offset 0x10 or at 0x1C.

Top module: `cdown_timer`

## Requirements
- R1: After reset the control word, the pending flag and both count words read 0, and `irq_o` is low.
- R2: Byte offsets are fixed as follows. Start value low word 0x00 and high word 0x04, both readable. Live count low word 0x08 and high word 0x0C. Pending flag in bit 0 of 0x18. Control word at `CTRL_OFS`, 0x10 by default or 0x1C. Any other offset reads 0.
- R3: Control bit 0 is run. Writing it as 1 while the timer is stopped copies the full 64-bit start value into the counter. On each following clock the counter falls by one, and a borrow carries from the low word into the high word.
- R4: While run is 0, for example after writing 0 to the control word, the count holds its value.
- R5: With control bit 1 at 0 (periodic) and a start value of N-1, the pending flag is first set N clocks after the starting write. After that it is set every N clocks, and the counter reloads from the start value each time.
- R6: With control bit 1 at 1 (single-shot) and a start value of N-1, the flag is set once, N clocks after the start. The counter then stays at 0 and raises no further events until run is cleared and set again.
- R7: Control bit 2 enables the interrupt. `irq_o` is high only while both the pending flag and this bit are 1. A masked event still sets the flag, and the flag can be read.
- R8: Writing 1 to bit 0 at 0x18 clears the pending flag, and writing 0 leaves it unchanged. If an event and a clearing write fall in the same cycle, the flag stays set.
- R9: Start-value writes made while running are stored but do not change the current count or the reload value until the next start.
- R10: A control write with run=1 while the timer is already running updates the mode and interrupt enable without restarting the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for bus and counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Peripheral select |
| bus_en | input | 1 | Access phase strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while selected |
| irq_o | output | 1 | Interrupt, pending flag gated by enable |

## Verification
The bench measures when the first event arrives and the spacing between events against the cycle of the starting write, because an off-by-one in the reload or the start load shifts both by one clock. It rewrites the start value while the timer runs and checks that the period does not change until a restart, which catches a design that reloads from the live register. A single-shot run is watched for a second event that should never come. A zero start value makes an event occur in every cycle, so a clearing write that took priority over the event would show as a dropped interrupt. A 64-bit start value just above a word boundary exposes a missing borrow into the high word.

// File: rtl/cdown_timer_pkg.sv
package cdown_timer_pkg;

  typedef enum logic {
    MODE_FREE  = 1'b0,
    MODE_COUNT = 1'b1
  } cnt_mode_e;

  // control word layout: bit 0 run, bit 1 mode, bit 2 interrupt enable
  typedef struct packed {
    logic      irq_en;
    cnt_mode_e mode;
    logic      run;
  } ctrl_t;

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned OFS_LOAD   = 0;
  localparam int unsigned OFS_CUR    = 8;
  localparam int unsigned OFS_STAT   = 24;
  localparam int unsigned CTRL_OFS_A = 16;
  localparam int unsigned CTRL_OFS_B = 28;

endpackage

// File: rtl/cdown_regs.sv
module cdown_regs
  import cdown_timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int CTRL_OFS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_en,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [2*DATA_W-1:0]   cnt_val,
  input  logic                  flag,
  output logic [2*DATA_W-1:0]   load_val,
  output ctrl_t                 ctrl,
  output logic                  start,
  output logic                  clr
);

  localparam int NWORDS = 2;

  logic wr_stb;
  logic ctrl_hit;
  logic stat_hit;
  logic unused_wdata;

  assign wr_stb       = bus_sel & bus_en & bus_wr;
  assign ctrl_hit     = (bus_addr == ADDR_W'(CTRL_OFS));
  assign stat_hit     = (bus_addr == ADDR_W'(OFS_STAT));
  assign unused_wdata = ^bus_wdata[DATA_W-1:3];

  // start value words
  for (genvar w = 0; w < NWORDS; w++) begin : g_load
    logic              word_ce;
    logic [DATA_W-1:0] word_d;
    logic [DATA_W-1:0] word_q;

    always_comb begin
      word_ce = wr_stb && (bus_addr == ADDR_W'(OFS_LOAD + w * WORD_BYTES));
      word_d  = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_ce) begin
        word_q <= word_d;
      end
    end

    assign load_val[w*DATA_W +: DATA_W] = word_q;
  end

  // control word
  ctrl_t ctrl_d;
  ctrl_t ctrl_q;
  logic  ctrl_ce;

  always_comb begin
    ctrl_ce = wr_stb & ctrl_hit;
    ctrl_d  = ctrl_t'(bus_wdata[2:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_ce) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl  = ctrl_q;
  assign start = ctrl_ce & bus_wdata[0] & ~ctrl_q.run;
  assign clr   = wr_stb & stat_hit & bus_wdata[0];

  // read multiplexer
  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (bus_addr == ADDR_W'(OFS_LOAD + w * WORD_BYTES)) begin
          bus_rdata = load_val[w*DATA_W +: DATA_W];
        end
        if (bus_addr == ADDR_W'(OFS_CUR + w * WORD_BYTES)) begin
          bus_rdata = cnt_val[w*DATA_W +: DATA_W];
        end
      end
      if (ctrl_hit) begin
        bus_rdata[2:0] = ctrl_q;
      end
      if (stat_hit) begin
        bus_rdata[0] = flag;
      end
    end
  end

endmodule

// File: rtl/cdown_core.sv
module cdown_core
  import cdown_timer_pkg::*;
#(
  parameter int COUNT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  cnt_mode_e          mode,
  input  logic               start,
  input  logic [COUNT_W-1:0] load_val,
  output logic [COUNT_W-1:0] cnt,
  output logic [COUNT_W-1:0] act_load,
  output logic               tc,
  output logic               done
);

  logic [COUNT_W-1:0] cnt_d, cnt_q;
  logic [COUNT_W-1:0] act_d, act_q;
  logic               done_d, done_q;
  logic               at_zero;
  logic               core_ce;

  assign at_zero = (cnt_q == '0);
  assign core_ce = start | run;

  always_comb begin
    cnt_d  = cnt_q;
    act_d  = act_q;
    done_d = done_q;
    tc     = 1'b0;
    if (start) begin
      cnt_d  = load_val;
      act_d  = load_val;
      done_d = 1'b0;
    end else if (run) begin
      if (at_zero) begin
        if (mode == MODE_FREE) begin
          tc    = 1'b1;
          cnt_d = act_q;
        end else if (!done_q) begin
          tc     = 1'b1;
          done_d = 1'b1;
        end
      end else begin
        cnt_d = cnt_q - COUNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= '0;
      done_q <= 1'b0;
    end else if (core_ce) begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      done_q <= done_d;
    end
  end

  assign cnt      = cnt_q;
  assign act_load = act_q;
  assign done     = done_q;

endmodule

// File: rtl/cdown_irq.sv
module cdown_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tc,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq_o
);

  logic flag_d, flag_q, flag_ce;

  always_comb begin
    flag_ce = tc | clr;
    if (tc) begin
      flag_d = 1'b1;
    end else begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_ce) begin
      flag_q <= flag_d;
    end
  end

  assign flag  = flag_q;
  assign irq_o = flag_q & irq_en;

endmodule

// File: rtl/cdown_timer.sv
module cdown_timer
  import cdown_timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int CTRL_OFS = CTRL_OFS_A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  localparam int COUNT_W = 2 * DATA_W;

  ctrl_t              ctrl;
  logic               start;
  logic               clr;
  logic               tc;
  logic               flag;
  logic               done;
  logic [COUNT_W-1:0] cnt;
  logic [COUNT_W-1:0] act_load;
  logic [COUNT_W-1:0] load_val;

  cdown_regs #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .CTRL_OFS(CTRL_OFS)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_en   (bus_en),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cnt_val  (cnt),
    .flag     (flag),
    .load_val (load_val),
    .ctrl     (ctrl),
    .start    (start),
    .clr      (clr)
  );

  cdown_core #(
    .COUNT_W(COUNT_W)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl.run),
    .mode    (ctrl.mode),
    .start   (start),
    .load_val(load_val),
    .cnt     (cnt),
    .act_load(act_load),
    .tc      (tc),
    .done    (done)
  );

  cdown_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .tc    (tc),
    .clr   (clr),
    .irq_en(ctrl.irq_en),
    .flag  (flag),
    .irq_o (irq_o)
  );

endmodule

// File: rtl/cdown_timer_chk.sv
module cdown_timer_chk
  import cdown_timer_pkg::*;
#(
  parameter int COUNT_W = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input cnt_mode_e          mode,
  input logic               irq_en,
  input logic               start,
  input logic               clr,
  input logic               tc,
  input logic               flag,
  input logic               done,
  input logic               irq_o,
  input logic [COUNT_W-1:0] cnt,
  input logic [COUNT_W-1:0] act_load,
  input logic [COUNT_W-1:0] load_val
);

  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && cnt != '0) |=> (cnt == $past(cnt) - COUNT_W'(1)));

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(cnt));

  p_event_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> flag);

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && mode == MODE_FREE) |=> (cnt == $past(act_load)));

  p_single_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && mode == MODE_COUNT && done) |-> !tc);

  p_single_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && mode == MODE_COUNT && done) |=> (cnt == '0));

  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_o);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !tc) |=> !flag);

  p_start_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == $past(load_val) && act_load == $past(load_val)));

endmodule

bind cdown_timer cdown_timer_chk #(
  .COUNT_W(2 * DATA_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (ctrl.run),
  .mode    (ctrl.mode),
  .irq_en  (ctrl.irq_en),
  .start   (start),
  .clr     (clr),
  .tc      (tc),
  .flag    (flag),
  .done    (done),
  .irq_o   (irq_o),
  .cnt     (cnt),
  .act_load(act_load),
  .load_val(load_val)
);

// File: tb/sim_cdown_timer.sv
`timescale 1ns/1ps
module sim_cdown_timer;

  localparam logic [7:0] A_LLO  = 8'h00;
  localparam logic [7:0] A_LHI  = 8'h04;
  localparam logic [7:0] A_CLO  = 8'h08;
  localparam logic [7:0] A_CHI  = 8'h0C;
  localparam logic [7:0] A_CTRL = 8'h10;
  localparam logic [7:0] A_STAT = 8'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int rise_cnt = 0;
  int last_rise = 0;
  logic irq_prev = 1'b0;

  always #2 clk = ~clk;

  cdown_timer #(.DATA_W(32), .ADDR_W(8), .CTRL_OFS(16)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (irq_o === 1'b1 && irq_prev === 1'b0) begin
      rise_cnt  = rise_cnt + 1;
      last_rise = cyc;
    end
    irq_prev = irq_o;
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int c);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_en = 1'b0; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b1;
    @(posedge clk);
    #1;
    c = cyc;
    bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output int c);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_en = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b1;
    #1;
    d = bus_rdata;
    c = cyc;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_en = 1'b0;
  endtask

  task automatic wait_rise(input int rc);
    while (rise_cnt == rc) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d; int c;
    chk(irq_o, 0, "R1 irq after reset");
    rd(A_CTRL, d, c); chk(d, 0, "R1 ctrl after reset");
    rd(A_STAT, d, c); chk(d, 0, "R1 status after reset");
    rd(A_CLO, d, c);  chk(d, 0, "R1 count low after reset");
    rd(A_CHI, d, c);  chk(d, 0, "R1 count high after reset");
  endtask

  task automatic t_regmap();
    logic [31:0] d; int c;
    wr(A_LLO, 32'h1234_5678, c);
    wr(A_LHI, 32'h9ABC_DEF0, c);
    rd(A_LLO, d, c); chk(d, 32'h1234_5678, "R2 start low readback");
    rd(A_LHI, d, c); chk(d, 32'h9ABC_DEF0, "R2 start high readback");
    rd(8'h1C, d, c); chk(d, 0, "R2 unused offset 0x1C");
    rd(8'h14, d, c); chk(d, 0, "R2 unused offset 0x14");
    rd(A_CLO, d, c); chk(d, 0, "R2 count untouched while stopped");
  endtask

  task automatic t_count64();
    logic [31:0] d; int a, b, c;
    logic [63:0] ld, v;
    ld = 64'h0000_0001_0000_0002;
    wr(A_LLO, 32'h2, c);
    wr(A_LHI, 32'h1, c);
    wr(A_CTRL, 32'h1, a);
    rd(A_CLO, d, c);
    v = ld - 64'(c - a);
    chk(d, v[31:0], "R3 live count falls one per clock");
    wr(A_CTRL, 32'h0, b);
    v = ld - 64'(b - a);
    rd(A_CLO, d, c); chk(d, v[31:0], "R3 low word after borrow");
    rd(A_CHI, d, c); chk(d, v[63:32], "R3 high word after borrow");
    repeat (10) @(negedge clk);
    rd(A_CLO, d, c); chk(d, v[31:0], "R4 count frozen when stopped");
    wr(A_LHI, 32'h0, c);
  endtask

  task automatic t_free();
    logic [31:0] d; int a, c, r1, r2, rc;
    wr(A_STAT, 32'h1, c);
    wr(A_LLO, 32'd9, c);
    rc = rise_cnt;
    wr(A_CTRL, 32'h5, a);
    rd(A_CTRL, d, c); chk(d, 32'h5, "R2 ctrl readback");
    wait_rise(rc);
    chk(64'(last_rise), 64'(a + 10), "R5 first event after N clocks");
    wr(A_LLO, 32'd29, c);
    wr(A_STAT, 32'h1, c);
    rc = rise_cnt; wait_rise(rc); r1 = last_rise;
    wr(A_STAT, 32'h1, c);
    rc = rise_cnt; wait_rise(rc); r2 = last_rise;
    chk(64'(r2 - r1), 64'd10, "R9 running period ignores new start value");
    wr(A_CTRL, 32'h0, c);
    wr(A_STAT, 32'h1, c);
    rc = rise_cnt;
    wr(A_CTRL, 32'h5, a);
    wait_rise(rc);
    chk(64'(last_rise), 64'(a + 30), "R9 new start value used after restart");
    wr(A_STAT, 32'h1, c);
    rc = rise_cnt; wait_rise(rc); r1 = last_rise;
    wr(A_STAT, 32'h1, c);
    rc = rise_cnt; wait_rise(rc); r2 = last_rise;
    chk(64'(r2 - r1), 64'd30, "R5 periodic spacing of N clocks");
    wr(A_CTRL, 32'h0, c);
    wr(A_STAT, 32'h1, c);
  endtask

  task automatic t_single();
    logic [31:0] d; int a, c, rc;
    wr(A_LLO, 32'd4, c);
    rc = rise_cnt;
    wr(A_CTRL, 32'h7, a);
    wait_rise(rc);
    chk(64'(last_rise), 64'(a + 5), "R6 single event after N clocks");
    wr(A_STAT, 32'h1, c);
    repeat (30) @(negedge clk);
    chk(irq_o, 0, "R6 no second event");
    rd(A_STAT, d, c); chk(d, 0, "R6 flag stays clear");
    rd(A_CLO, d, c);  chk(d, 0, "R6 count rests at zero");
    wr(A_CTRL, 32'h0, c);
    rc = rise_cnt;
    wr(A_CTRL, 32'h7, a);
    wait_rise(rc);
    chk(64'(last_rise), 64'(a + 5), "R6 rearmed by restart");
    wr(A_CTRL, 32'h0, c);
    wr(A_STAT, 32'h1, c);
  endtask

  task automatic t_mask();
    logic [31:0] d; int c;
    wr(A_LLO, 32'd3, c);
    wr(A_CTRL, 32'h1, c);
    repeat (20) @(negedge clk);
    chk(irq_o, 0, "R7 masked event keeps irq low");
    rd(A_STAT, d, c); chk(d, 1, "R7 masked event visible in flag");
    wr(A_CTRL, 32'h5, c);
    chk(irq_o, 1, "R7 enabling interrupt raises irq");
    wr(A_CTRL, 32'h4, c);
    wr(A_STAT, 32'h0, c);
    chk(irq_o, 1, "R8 writing zero keeps flag");
    rd(A_STAT, d, c); chk(d, 1, "R8 flag still set after zero write");
    wr(A_STAT, 32'h1, c);
    chk(irq_o, 0, "R8 writing one clears flag");
  endtask

  task automatic t_restart();
    logic [31:0] d; int a, b, c;
    wr(A_LLO, 32'd99, c);
    wr(A_CTRL, 32'h1, a);
    repeat (5) @(negedge clk);
    wr(A_CTRL, 32'h5, c);
    wr(A_CTRL, 32'h0, b);
    rd(A_CLO, d, c);
    chk(d, 32'(99 - (b - a)), "R10 rewrite of run does not restart");
    wr(A_STAT, 32'h1, c);
  endtask

  task automatic t_collide();
    int c;
    wr(A_LLO, 32'd0, c);
    wr(A_CTRL, 32'h5, c);
    wr(A_STAT, 32'h1, c);
    chk(irq_o, 1, "R8 event wins over same-cycle clear");
    wr(A_CTRL, 32'h0, c);
    wr(A_STAT, 32'h1, c);
    chk(irq_o, 0, "R8 clear once stopped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_count64();
    t_free();
    t_single();
    t_mask();
    t_restart();
    t_collide();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule